// File: doc/BRIEF.md
# Banked Private Peripheral Address Decoder

This block sits on the bus port of a four-processor cluster. It steers each access inside a 4 KB private region to one of three kinds of local resource. It looks only at the low 12 bits of the address and the ID of the processor that makes the access. From these it produces three values, all combinationally:
- a target code,
- a bank index, which is a processor number or a timer number,
- the offset inside the selected register window.

There are two interrupt-interface windows and two timer windows. In each pair, one window always resolves to the requesting processor's own bank, and the other indexes a processor explicitly, 256 bytes per processor. Each processor owns two timers, a general timer and a watchdog, and address bit 5 chooses between them. For a timer access the block also returns the number of the private interrupt that timer raises.

The block holds one small register file of its own, the snoop-control registers. It returns their read data and flags an error for offsets it does not decode. The timers and the interrupt interface sit outside the block, and the block only selects them.

Top module: `priv_region_decoder`

## Requirements
- R1: Only address bits [11:0] are decoded. Two addresses that differ only above bit 11 give identical outputs.
- R2: Offsets 0x000–0x0FF select target code 1 (snoop). A write to offset 0x00 stores write-data bit 0 in a control bit that resets to 0. A read of 0x00 returns that bit in bit 0 and zero in all other bits.
- R3: In the snoop window:
  - offset 0x04 reads 0x000000F3,
  - offsets 0x08 and 0x0C read zero,
  - a write to 0x0C gives no error and leaves the control bit unchanged.
- R4: The following raise `err` when `acc_valid` is 1, return zero read data and leave the control bit unchanged:
  - any snoop offset other than 0x00, 0x04, 0x08 and 0x0C,
  - a write to 0x04 or 0x08.
- R5: Offsets 0x100–0x1FF select target code 2 (interrupt interface) with bank = `req_cpu` and local offset = address[7:0].
- R6: Offsets 0x200–0x5FF select target code 2 with bank = (offset − 0x200) >> 8 and local offset = address[7:0].
- R7: Offsets 0x600–0x6FF select target code 3 (timer) with bank = 2·`req_cpu` + address[5] and local offset = address[3:0], upper local bits zero.
- R8: Offsets 0x700–0xAFF select target code 3 with bank = 2·((offset − 0x700) >> 8) + address[5] and local offset = address[3:0].
- R9: For a timer target, `irq_num` is 29 when address[5] is 0 (timer) and 30 when it is 1 (watchdog). For any other target it is 0.
- R10: Offsets 0xB00–0xFFF give target code 0, bank 0, local offset 0 and zero read data. They raise `err` when `acc_valid` is 1.
- R11: The target code, bank, local offset, interrupt number, read data and error all follow the address and `req_cpu` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the snoop-control register |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_cpu | input | 2 | ID of the requesting processor |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Access address; bits [11:0] are decoded |
| acc_wdata | input | 32 | Write data |
| tgt_sel | output | 2 | Target code: 0 none, 1 snoop, 2 interrupt interface, 3 timer |
| bank_idx | output | 3 | Processor number (interrupt interface) or timer number (timers) |
| local_off | output | 8 | Offset inside the selected window |
| irq_num | output | 5 | Private interrupt raised by the selected timer |
| rdata | output | 32 | Snoop-control read data; zero otherwise |
| err | output | 1 | Error response for an undecoded access |

## Verification
The control bit is the only state in the block. If it is corrupted or written at the wrong time, the next read of offset 0x00 shows the wrong bit0, one cycle after the faulty write. All other outputs are combinational. A wrong window boundary or a wrong bank computation therefore appears on `tgt_sel`, `bank_idx` or `local_off` in the same cycle that the address is presented. Boundary addresses on each side of every window edge, and both values of address bit 5, expose such a fault at once.

// File: rtl/priv_dec_pkg.sv
package priv_dec_pkg;
   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_SNOOP = 2'd1,
      TGT_INTC  = 2'd2,
      TGT_TIMER = 2'd3
   } tgt_e;
endpackage

// File: rtl/priv_win_decode.sv
module priv_win_decode
   import priv_dec_pkg::*;
#(
   parameter int NCPU    = 4,
   parameter int CPU_W   = $clog2(NCPU),
   parameter int BANK_W  = CPU_W + 1,
   parameter int WIN_SZ  = 256
) (
   input  logic [11:0]       off,
   input  logic [CPU_W-1:0]  req_cpu,
   output tgt_e              tgt,
   output logic [BANK_W-1:0] bank,
   output logic [7:0]        loc
);
   localparam int INTC_OWN = WIN_SZ;
   localparam int INTC_EXP = 2 * WIN_SZ;
   localparam int TMR_OWN  = INTC_EXP + NCPU * WIN_SZ;
   localparam int TMR_EXP  = TMR_OWN + WIN_SZ;
   localparam int REG_END  = TMR_EXP + NCPU * WIN_SZ;

   generate
      if (NCPU < 2 || (NCPU & (NCPU - 1)) != 0)
         $error("priv_win_decode: NCPU must be a power of two, at least 2");
      if (REG_END > 4096)
         $error("priv_win_decode: windows exceed the 4 KB region");
      if (WIN_SZ != 256)
         $error("priv_win_decode: window size must be 256 bytes");
   endgenerate

   logic [11:0] intc_rel;
   logic [11:0] tmr_rel;
   assign intc_rel = off - 12'(INTC_EXP);
   assign tmr_rel  = off - 12'(TMR_EXP);

   always_comb begin
      tgt  = TGT_NONE;
      bank = '0;
      loc  = '0;
      if (off < 12'(INTC_OWN)) begin
         tgt = TGT_SNOOP;
         loc = off[7:0];
      end else if (off < 12'(INTC_EXP)) begin
         tgt  = TGT_INTC;
         bank = BANK_W'(req_cpu);
         loc  = off[7:0];
      end else if (off < 12'(TMR_OWN)) begin
         tgt  = TGT_INTC;
         bank = BANK_W'(intc_rel[8 +: CPU_W]);
         loc  = off[7:0];
      end else if (off < 12'(TMR_EXP)) begin
         tgt  = TGT_TIMER;
         bank = {req_cpu, off[5]};
         loc  = {4'b0, off[3:0]};
      end else if (off < 12'(REG_END)) begin
         tgt  = TGT_TIMER;
         bank = {tmr_rel[8 +: CPU_W], off[5]};
         loc  = {4'b0, off[3:0]};
      end
   end
endmodule

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs #(
   parameter int         DATA_W  = 32,
   parameter logic [7:0] CFG_VAL = 8'hF3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [7:0]        off,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              bad
);
   generate
      if (DATA_W < 8)
         $error("snoop_ctl_regs: DATA_W must hold the configuration value");
   endgenerate

   logic ctrl_q;
   logic wr_ctrl;
   logic unused_wdata;
   assign unused_wdata = ^wdata[DATA_W-1:1];

   always_comb begin
      rdata = '0;
      bad   = 1'b0;
      unique case (off)
         8'h00: rdata = DATA_W'(ctrl_q);
         8'h04: begin rdata = DATA_W'(CFG_VAL); bad = wr; end
         8'h08: bad = wr;
         8'h0C: ;
         default: bad = 1'b1;
      endcase
      if (bad) rdata = '0;
   end

   assign wr_ctrl = sel && wr && (off == 8'h00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= 1'b0;
      else if (wr_ctrl) ctrl_q <= wdata[0];
   end

   a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && wr && off == 8'h00) |=> $stable(ctrl_q));
   a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && off == 8'h00) |=> ctrl_q == $past(wdata[0]));
   a_r4_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bad |-> rdata == '0);
endmodule

// File: rtl/priv_region_decoder.sv
module priv_region_decoder
   import priv_dec_pkg::*;
#(
   parameter int NCPU     = 4,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int TMR_IRQ  = 29,
   parameter int WDOG_IRQ = 30,
   parameter int CPU_W    = $clog2(NCPU),
   parameter int BANK_W   = CPU_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_W-1:0]  req_cpu,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [1:0]        tgt_sel,
   output logic [BANK_W-1:0] bank_idx,
   output logic [7:0]        local_off,
   output logic [4:0]        irq_num,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);
   localparam int OFF_END = 2 * 256 + 2 * NCPU * 256 + 256;

   generate
      if (ADDR_W < 12)
         $error("priv_region_decoder: ADDR_W must cover the 4 KB region");
      if (TMR_IRQ > 31 || WDOG_IRQ > 31)
         $error("priv_region_decoder: interrupt numbers need five bits");
   endgenerate

   logic [11:0]       off;
   logic              unused_addr;
   tgt_e              tgt;
   logic [DATA_W-1:0] snp_rdata;
   logic              snp_bad;
   logic              snp_sel;

   assign off         = acc_addr[11:0];
   assign unused_addr = ^acc_addr[ADDR_W-1:12];

   priv_win_decode #(.NCPU(NCPU), .CPU_W(CPU_W), .BANK_W(BANK_W)) u_dec (
      .off     (off),
      .req_cpu (req_cpu),
      .tgt     (tgt),
      .bank    (bank_idx),
      .loc     (local_off)
   );

   assign snp_sel = acc_valid && (tgt == TGT_SNOOP);

   snoop_ctl_regs #(.DATA_W(DATA_W)) u_snp (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (snp_sel),
      .wr    (acc_write),
      .off   (local_off),
      .wdata (acc_wdata),
      .rdata (snp_rdata),
      .bad   (snp_bad)
   );

   assign tgt_sel = tgt;
   assign rdata   = (tgt == TGT_SNOOP) ? snp_rdata : '0;
   assign err     = acc_valid && ((tgt == TGT_NONE) || (tgt == TGT_SNOOP && snp_bad));
   assign irq_num = (tgt != TGT_TIMER) ? 5'd0 :
                    (bank_idx[0] ? 5'(WDOG_IRQ) : 5'(TMR_IRQ));

   a_r10_high_err: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && off >= 12'(OFF_END)) |-> (err && tgt_sel == 2'd0 && rdata == '0));
   a_r9_irq_pick: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel == 2'd3) |-> (irq_num == (acc_addr[5] ? 5'(WDOG_IRQ) : 5'(TMR_IRQ))));
   a_r7_own_timer: assert property (@(posedge clk) disable iff (!rst_n)
      (off >= 12'(512 + NCPU * 256) && off < 12'(768 + NCPU * 256)) |->
      (bank_idx[BANK_W-1:1] == req_cpu && local_off[7:4] == 4'd0));
   a_r5_own_intc: assert property (@(posedge clk) disable iff (!rst_n)
      (off[11:8] == 4'd1) |-> (tgt_sel == 2'd2 && bank_idx == BANK_W'(req_cpu)));
endmodule

// File: tb/priv_region_decoder_tb.sv
`timescale 1ns/1ps
module priv_region_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  req_cpu = '0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [1:0]  tgt_sel;
   logic [2:0]  bank_idx;
   logic [7:0]  local_off;
   logic [4:0]  irq_num;
   logic [31:0] rdata;
   logic        err;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   priv_region_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .req_cpu(req_cpu), .acc_valid(acc_valid),
      .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .tgt_sel(tgt_sel), .bank_idx(bank_idx), .local_off(local_off),
      .irq_num(irq_num), .rdata(rdata), .err(err)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  cpu;
      logic [1:0]  tgt;
      logic [2:0]  bank;
      logic [7:0]  off;
      logic        err;
      logic [31:0] rd;
      logic [4:0]  irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{32'h000, 2'd0, 2'd1, 3'd0, 8'h00, 1'b0, 32'h0,  5'd0,  4'd2},  // R2
      '{32'h004, 2'd2, 2'd1, 3'd0, 8'h04, 1'b0, 32'hF3, 5'd0,  4'd3},  // R3
      '{32'h008, 2'd1, 2'd1, 3'd0, 8'h08, 1'b0, 32'h0,  5'd0,  4'd3},  // R3
      '{32'h00C, 2'd3, 2'd1, 3'd0, 8'h0C, 1'b0, 32'h0,  5'd0,  4'd3},  // R3
      '{32'h010, 2'd0, 2'd1, 3'd0, 8'h10, 1'b1, 32'h0,  5'd0,  4'd4},  // R4
      '{32'h0FC, 2'd1, 2'd1, 3'd0, 8'hFC, 1'b1, 32'h0,  5'd0,  4'd4},  // R4
      '{32'h1A4, 2'd3, 2'd2, 3'd3, 8'hA4, 1'b0, 32'h0,  5'd0,  4'd5},  // R5
      '{32'h104, 2'd0, 2'd2, 3'd0, 8'h04, 1'b0, 32'h0,  5'd0,  4'd5},  // R5
      '{32'h200, 2'd3, 2'd2, 3'd0, 8'h00, 1'b0, 32'h0,  5'd0,  4'd6},  // R6
      '{32'h3FF, 2'd0, 2'd2, 3'd1, 8'hFF, 1'b0, 32'h0,  5'd0,  4'd6},  // R6
      '{32'h5F0, 2'd0, 2'd2, 3'd3, 8'hF0, 1'b0, 32'h0,  5'd0,  4'd6},  // R6
      '{32'h600, 2'd1, 2'd3, 3'd2, 8'h00, 1'b0, 32'h0,  5'd29, 4'd7},  // R7
      '{32'h62C, 2'd1, 2'd3, 3'd3, 8'h0C, 1'b0, 32'h0,  5'd30, 4'd7},  // R7 R9
      '{32'h60F, 2'd3, 2'd3, 3'd6, 8'h0F, 1'b0, 32'h0,  5'd29, 4'd7},  // R7
      '{32'h720, 2'd0, 2'd3, 3'd1, 8'h00, 1'b0, 32'h0,  5'd30, 4'd8},  // R8 R9
      '{32'h80C, 2'd0, 2'd3, 3'd2, 8'h0C, 1'b0, 32'h0,  5'd29, 4'd8},  // R8
      '{32'hA3A, 2'd2, 2'd3, 3'd7, 8'h0A, 1'b0, 32'h0,  5'd30, 4'd8},  // R8 R9
      '{32'hB00, 2'd0, 2'd0, 3'd0, 8'h00, 1'b1, 32'h0,  5'd0,  4'd10}, // R10
      '{32'hFFC, 2'd3, 2'd0, 3'd0, 8'h00, 1'b1, 32'h0,  5'd0,  4'd10}, // R10
      '{32'h12345604, 2'd2, 2'd3, 3'd4, 8'h04, 1'b0, 32'h0, 5'd29, 4'd1}, // R1
      '{32'hFFFFF004, 2'd0, 2'd1, 3'd0, 8'h04, 1'b0, 32'hF3, 5'd0, 4'd1}  // R1
   };

   task automatic check(input string what, input int req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic access(input logic [31:0] a, input logic [1:0] c,
                         input logic w, input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = w; acc_addr = a; req_cpu = c; acc_wdata = d;
      #1;
   endtask

   task automatic read_ctrl(input int req, input logic [31:0] exp);
      access(32'h0, 2'd0, 1'b0, 32'h0);
      check("ctrl readback", req, rdata, exp);
   endtask

   initial begin
      #8000;
      if (!done) begin
         n_bad++;
         $display("FAIL R11 watchdog: actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2: control bit is zero after reset
      read_ctrl(2, 32'h0);
      // R1 R3..R10 R11: combinational decode table, sampled 1 ns after the input change
      for (int i = 0; i < NV; i++) begin
         access(VEC[i].addr, VEC[i].cpu, 1'b0, 32'h0);
         check("tgt",   int'(VEC[i].req), 32'(tgt_sel),   32'(VEC[i].tgt));
         check("bank",  int'(VEC[i].req), 32'(bank_idx),  32'(VEC[i].bank));
         check("off",   int'(VEC[i].req), 32'(local_off), 32'(VEC[i].off));
         check("err",   int'(VEC[i].req), 32'(err),       32'(VEC[i].err));
         check("rdata", int'(VEC[i].req), rdata,          VEC[i].rd);
         check("irq",   int'(VEC[i].req), 32'(irq_num),   32'(VEC[i].irq));
      end
      // R2: write all ones, only bit 0 is stored
      access(32'h0, 2'd1, 1'b1, 32'hFFFF_FFFF);
      check("ctrl write err", 2, 32'(err), 32'h0);
      read_ctrl(2, 32'h1);
      // R3: write to 0x0C is accepted and leaves the control bit unchanged
      access(32'h00C, 2'd0, 1'b1, 32'h0);
      check("invalidate err", 3, 32'(err), 32'h0);
      read_ctrl(3, 32'h1);
      // R4: writes to 0x04, 0x08 and an undefined offset give an error and no change
      access(32'h004, 2'd0, 1'b1, 32'h0);
      check("cfg write err", 4, 32'(err), 32'h1);
      access(32'h008, 2'd0, 1'b1, 32'h0);
      check("status write err", 4, 32'(err), 32'h1);
      access(32'h020, 2'd0, 1'b1, 32'h0);
      check("undef write err", 4, 32'(err), 32'h1);
      read_ctrl(4, 32'h1);
      // R1: aliased address above bit 11 reaches the control register
      access(32'hABC0_0000, 2'd2, 1'b1, 32'h0);
      read_ctrl(1, 32'h0);
      // R10: no error when no access is present
      access(32'hC00, 2'd0, 1'b0, 32'h0);
      acc_valid = 1'b0;
      #1;
      check("idle err", 10, 32'(err), 32'h0);
      // R2: reset clears the stored bit
      access(32'h0, 2'd0, 1'b1, 32'h1);
      @(negedge clk);
      acc_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      read_ctrl(2, 32'h0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule